// File: doc/BRIEF.md
# Strap-Configured Host Register Bridge

This block connects an external microcontroller bus to the register file inside a chip. The host selects the bridge with an active-low chip select and picks one of sixteen register slots on four address lines. Three strap pins fix the shape of the bus, and the bridge reads them only while reset is held. One strap sets the data width to 8 or 16 bits. One sets which half of the 16-bit bus carries the most significant byte. One picks a handshake. The first handshake uses a direction line plus an active-low data strobe. The second uses separate active-low write and read strobes.

The bridge passes the bus strobes through synchronizers and decodes them into single-cycle read and write pulses toward the register file. It steers bytes between the bus lanes and a logical 16-bit word. It drives an acknowledge output. Under the first handshake this output marks that the access is complete. Under the second it marks a one-cycle wait. The bridge owns four slots itself. Slot 0 pushes a code byte into a small FIFO. Slot 1 returns pending interrupt events and clears them on read. Slot 2 holds the interrupt enable mask. Slot 3 holds the burst length. A ready flag tells the host how many more code bytes it may send without polling.

Top module: `hostbus_bridge`

## Requirements
- R1: The strap values are captured on every clock while `rst` is high and held unchanged after that. Strap changes after reset have no effect on decoding, steering or the handshake.
- R2: With the protocol strap low, an access starts when `ctl_b` goes low while `cs_n` is low. In this mode `ctl_a` high means read and low means write. `ack_n` goes low while the access is held and is high again within five cycles after the strobe is released.
- R3: With the protocol strap high, `ctl_a` is an active-low write strobe and `ctl_b` is an active-low read strobe. `ack_n` is low for exactly one cycle per access.
- R4: A write to slot 4 or higher produces exactly one `reg_wr` pulse after the strobe is released. The pulse carries the slot on `reg_addr` and the logical word on `reg_wdata`.
- R5: A read from slot 4 or higher produces exactly one `reg_rd` pulse. While the access is held, `dout_en` is high and `dout` carries `reg_rdata`, steered onto the bus lanes.
- R6: In 16-bit mode with the order strap low, bus bits 15:8 hold the logical bits 15:8. With the order strap high, the two bytes are exchanged, both for writes and for reads.
- R7: In 8-bit mode, `din[15:8]` is ignored and the upper byte of the logical word is 0. `dout[15:8]` reads 0 and the order strap has no effect.
- R8: Each `evt` bit that is high in a cycle sets a pending bit. `irq_n` is low whenever a pending bit is set and its mask bit (slot 2, bit n enables event n) is 1. After reset, the mask is 0 and `irq_n` is high.
- R9: A read of slot 1 returns the pending bits as they were before the read, in bits NEVT-1:0, and clears them. An event that arrives in the same cycle as the clear stays pending.
- R10: Writing 0 to the mask register releases `irq_n` while the pending bits stay set.
- R11: A write to slot 0 pushes bits 7:0 of the logical word into the code FIFO. `rdy` is high exactly while the free space is greater than the burst length (slot 3, reset value 4) plus 2. Once `rdy` falls, two more bytes are still accepted.
- R12: Code bytes leave on `code_data` in the order they were written. `code_valid` shows the FIFO is not empty, and `code_pop` removes the head byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| strap_swap | input | 1 | 1 = most significant byte on bits 7:0 in 16-bit mode |
| strap_protb | input | 1 | 0 = direction/strobe handshake, 1 = separate strobes |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 4 | Register slot |
| ctl_a | input | 1 | Read/not-write (protocol 0) or write strobe, active low (protocol 1) |
| ctl_b | input | 1 | Data strobe (protocol 0) or read strobe (protocol 1), active low |
| din | input | 16 | Bus write data |
| dout | output | 16 | Bus read data |
| dout_en | output | 1 | Read data drive enable |
| ack_n | output | 1 | Completion (protocol 0) or wait (protocol 1), active low |
| rdy | output | 1 | Code burst ready flag |
| irq_n | output | 1 | Active-low interrupt request |
| reg_wr | output | 1 | Register file write pulse |
| reg_rd | output | 1 | Register file read pulse |
| reg_addr | output | 4 | Register file slot |
| reg_wdata | output | 16 | Register file write word |
| reg_rdata | input | 16 | Register file read word for `reg_addr` |
| evt | input | NEVT | Interrupt event pulses |
| code_pop | input | 1 | Remove head code byte |
| code_valid | output | 1 | Code FIFO not empty |
| code_data | output | 8 | Head code byte |

## Verification
A status read and a new event can land on the same clock edge. The clear of the pending bits and the setting of a fresh bit then compete for the same register. The bench provokes this by pulsing an event exactly on the edge where the synchronized read strobe starts the access. It expects three things. The returned word excludes the new event. The interrupt stays asserted. A second status read returns only the new event and releases the interrupt.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    localparam int BUS_W  = 16;
    localparam int SLOT_W = 4;

    localparam logic [SLOT_W-1:0] SLOT_CODE  = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_STAT  = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_MASK  = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_BURST = 4'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SERV = 2'd1,
        ST_HOLD = 2'd2
    } acc_st_e;

    typedef struct packed {
        logic wide;
        logic swap;
        logic protb;
    } cfg_t;

    typedef struct packed {
        logic act;
        logic wr;
    } req_t;

    // Lane steering is its own inverse: used for both directions.
    function automatic logic [BUS_W-1:0] steer(input logic [BUS_W-1:0] w, input cfg_t c);
        if (!c.wide)
            return {8'h00, w[7:0]};
        else if (c.swap)
            return {w[7:0], w[15:8]};
        else
            return w;
    endfunction

    function automatic req_t decode(input logic cs_n, input logic a, input logic b,
                                    input logic protb);
        req_t r;
        if (protb) begin
            r.act = !cs_n && (!a || !b);
            r.wr  = !a;
        end else begin
            r.act = !cs_n && !b;
            r.wr  = !a;
        end
        return r;
    endfunction

    function automatic logic is_ext(input logic [SLOT_W-1:0] s);
        return s > SLOT_BURST;
    endfunction

endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
    parameter int W = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= {W{RST_VAL}};
            q  <= {W{RST_VAL}};
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/hbb_fifo.sv
module hbb_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic             valid,
    output logic [CNT_W-1:0] cnt
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign valid   = cnt != '0;
    assign do_push = push && (cnt != CNT_W'(DEPTH));
    assign do_pop  = pop && valid;
    assign rdata   = mem[rp];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/hbb_irq.sv
module hbb_irq #(
    parameter int NEVT = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEVT-1:0] evt,
    input  logic            clr,
    input  logic            mask_we,
    input  logic [NEVT-1:0] mask_d,
    output logic [NEVT-1:0] pending,
    output logic [NEVT-1:0] mask,
    output logic            irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            mask    <= '0;
        end else begin
            // a fresh event wins over a simultaneous clear
            pending <= (clr ? '0 : pending) | evt;
            if (mask_we) mask <= mask_d;
        end
    end

    assign irq_n = ~|(pending & mask);
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
    import hbb_pkg::*;
#(
    parameter int NEVT       = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int BURST_RST  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_wide,
    input  logic             strap_swap,
    input  logic             strap_protb,
    input  logic             cs_n,
    input  logic [3:0]       addr,
    input  logic             ctl_a,
    input  logic             ctl_b,
    input  logic [15:0]      din,
    output logic [15:0]      dout,
    output logic             dout_en,
    output logic             ack_n,
    output logic             rdy,
    output logic             irq_n,
    output logic             reg_wr,
    output logic             reg_rd,
    output logic [3:0]       reg_addr,
    output logic [15:0]      reg_wdata,
    input  logic [15:0]      reg_rdata,
    input  logic [NEVT-1:0]  evt,
    input  logic             code_pop,
    output logic             code_valid,
    output logic [7:0]       code_data
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    // strap capture, loaded only while reset is held
    cfg_t cfg_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.wide  <= strap_wide;
            cfg_q.swap  <= strap_swap & strap_wide;
            cfg_q.protb <= strap_protb;
        end
    end

    logic [2:0] syn;
    hbb_sync #(.W(3), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, ctl_a, ctl_b}),
        .q   (syn)
    );

    req_t req;
    assign req = decode(syn[2], syn[1], syn[0], cfg_q.protb);

    acc_st_e           st;
    logic [SLOT_W-1:0] addr_q;
    logic              wr_q;
    logic [BUS_W-1:0]  rd_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [CNT_W-1:0]  burst_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [NEVT-1:0]   pending, mask;
    logic [BUS_W-1:0]  rd_mux;

    logic start, commit, stat_clr, mask_we, burst_we, code_push;

    assign start    = (st == ST_IDLE) && req.act;
    assign commit   = (st == ST_HOLD) && !req.act && wr_q;
    assign stat_clr = start && !req.wr && (addr == SLOT_STAT);
    assign mask_we  = commit && (addr_q == SLOT_MASK);
    assign burst_we = commit && (addr_q == SLOT_BURST);
    assign code_push = commit && (addr_q == SLOT_CODE);

    always_comb begin
        rd_mux = '0;
        case (addr)
            SLOT_STAT:  rd_mux[NEVT-1:0]  = pending;
            SLOT_MASK:  rd_mux[NEVT-1:0]  = mask;
            SLOT_BURST: rd_mux[CNT_W-1:0] = burst_q;
            SLOT_CODE:  rd_mux = '0;
            default:    rd_mux = reg_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            rd_q    <= '0;
            wdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req.act) begin
                    st     <= ST_SERV;
                    addr_q <= addr;
                    wr_q   <= req.wr;
                    if (!req.wr) rd_q <= rd_mux;
                end
                ST_SERV: begin
                    st      <= ST_HOLD;
                    wdata_q <= steer(din, cfg_q);
                end
                ST_HOLD: if (!req.act) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           burst_q <= CNT_W'(BURST_RST);
        else if (burst_we) burst_q <= wdata_q[CNT_W-1:0];
    end

    assign reg_wr    = commit && is_ext(addr_q);
    assign reg_rd    = start && !req.wr && is_ext(addr);
    assign reg_addr  = (st == ST_IDLE) ? addr : addr_q;
    assign reg_wdata = wdata_q;
    assign dout_en   = (st != ST_IDLE) && !wr_q;
    assign dout      = steer(rd_q, cfg_q);
    assign ack_n     = cfg_q.protb ? (st != ST_SERV) : (st != ST_HOLD);

    hbb_irq #(.NEVT(NEVT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (stat_clr),
        .mask_we (mask_we),
        .mask_d  (wdata_q[NEVT-1:0]),
        .pending (pending),
        .mask    (mask),
        .irq_n   (irq_n)
    );

    hbb_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (code_push),
        .wdata (wdata_q[7:0]),
        .pop   (code_pop),
        .rdata (code_data),
        .valid (code_valid),
        .cnt   (fifo_cnt)
    );

    logic [CNT_W:0] free_sp, thresh;
    assign free_sp = (CNT_W + 1)'(FIFO_DEPTH) - {1'b0, fifo_cnt};
    assign thresh  = {1'b0, burst_q} + (CNT_W + 1)'(2);
    assign rdy     = free_sp > thresh;

endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
    parameter int NEVT  = 8,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             ack_n,
    input logic             irq_n,
    input logic             rdy,
    input logic [2:0]       cfg_q,
    input logic [NEVT-1:0]  evt,
    input logic             mask_we,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_q));

    // R3
    wait_once_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0] && !ack_n) |=> ack_n);

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($past(|evt) || $past(mask_we)));

    // R11
    rdy_margin_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (fifo_cnt <= CNT_W'(DEPTH - 3)));
endmodule

bind hostbus_bridge hostbus_bridge_chk #(.NEVT(NEVT), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .ack_n    (ack_n),
    .irq_n    (irq_n),
    .rdy      (rdy),
    .cfg_q    (cfg_q),
    .evt      (evt),
    .mask_we  (mask_we),
    .fifo_cnt (fifo_cnt)
);

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_wide = 1'b1, strap_swap = 1'b0, strap_protb = 1'b0;
    logic        cs_n = 1'b1, ctl_a = 1'b1, ctl_b = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en, ack_n, rdy, irq_n, reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [7:0]  evt = '0;
    logic        code_pop = 1'b0;
    logic        code_valid;
    logic [7:0]  code_data;

    always #2 clk = ~clk;

    assign reg_rdata = 16'hA5C0 | {12'h000, reg_addr};

    hostbus_bridge u_dut (
        .clk(clk), .rst(rst), .strap_wide(strap_wide), .strap_swap(strap_swap),
        .strap_protb(strap_protb), .cs_n(cs_n), .addr(addr), .ctl_a(ctl_a),
        .ctl_b(ctl_b), .din(din), .dout(dout), .dout_en(dout_en), .ack_n(ack_n),
        .rdy(rdy), .irq_n(irq_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt(evt), .code_pop(code_pop), .code_valid(code_valid), .code_data(code_data)
    );

    int n_chk = 0, n_bad = 0;
    int wr_seen = 0, rd_seen = 0;
    logic [3:0]  wr_a;
    logic [15:0] wr_d;
    bit tb_protb = 1'b0;

    always @(negedge clk) begin
        if (reg_wr) begin wr_seen++; wr_a = reg_addr; wr_d = reg_wdata; end
        if (reg_rd) rd_seen++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit w, input bit s, input bit p);
        @(negedge clk);
        rst = 1'b1; strap_wide = w; strap_swap = s; strap_protb = p;
        tb_protb = p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // scramble straps: must be ignored (R1)
        strap_wide = ~w; strap_swap = ~s; strap_protb = ~p;
        @(negedge clk);
    endtask

    task automatic access(input bit wr, input logic [3:0] a, input logic [15:0] d,
                          output logic [15:0] rdv, output int ack_low, output int ack_after);
        ack_low = 0; ack_after = 0; rdv = 'x;
        @(negedge clk);
        cs_n = 1'b0; addr = a; din = d;
        if (!tb_protb) begin ctl_a = ~wr; ctl_b = 1'b0; end
        else if (wr) ctl_a = 1'b0;
        else         ctl_b = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!ack_n) ack_low++;
            if (dout_en) rdv = dout;
        end
        cs_n = 1'b1; ctl_a = 1'b1; ctl_b = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!ack_n) ack_low++;
        end
        if (!ack_n) ack_after = 1;
    endtask

    task automatic t_reset_state();
        chk(irq_n === 1'b1, "R8 reset irq_n", irq_n, 1);
        chk(ack_n === 1'b1, "R2 reset ack_n", ack_n, 1);
        chk(rdy === 1'b1 && code_valid === 1'b0, "R11 reset rdy/valid", {rdy, code_valid}, 2);
        chk(dout_en === 1'b0, "R5 reset dout_en", dout_en, 0);
    endtask

    task automatic t_typea_wr_rd();
        logic [15:0] v; int al, aa, w0, r0;
        w0 = wr_seen;
        access(1'b1, 4'd5, 16'h1234, v, al, aa);
        chk(wr_seen == w0 + 1, "R4 one reg_wr", wr_seen - w0, 1);
        chk(wr_a == 4'd5 && wr_d == 16'h1234, "R4/R1/R6 write slot+data", {wr_a, wr_d}, 20'h51234);
        chk(al > 0 && aa == 0, "R2 ack completion", {al[7:0], aa[7:0]}, 1);
        r0 = rd_seen;
        access(1'b0, 4'd6, 16'h0000, v, al, aa);
        chk(rd_seen == r0 + 1, "R5 one reg_rd", rd_seen - r0, 1);
        chk(v == 16'hA5C6, "R5/R6 read data normal order", v, 16'hA5C6);
    endtask

    task automatic t_irq();
        logic [15:0] v; int al, aa;
        @(negedge clk); evt = 8'h08; @(negedge clk); evt = 8'h00;
        @(negedge clk);
        chk(irq_n === 1'b1, "R8 masked event no irq", irq_n, 1);
        access(1'b1, 4'd2, 16'h00FF, v, al, aa);
        chk(irq_n === 1'b0, "R8 enable pending -> irq", irq_n, 0);
        access(1'b0, 4'd1, 16'h0, v, al, aa);
        chk(v == 16'h0008, "R9 status value", v, 16'h0008);
        chk(irq_n === 1'b1, "R9 status read clears", irq_n, 1);
        @(negedge clk); evt = 8'h02; @(negedge clk); evt = 8'h00;
        @(negedge clk);
        chk(irq_n === 1'b0, "R8 event raises irq", irq_n, 0);
        access(1'b1, 4'd2, 16'h0000, v, al, aa);
        chk(irq_n === 1'b1, "R10 mask off releases irq", irq_n, 1);
        access(1'b0, 4'd1, 16'h0, v, al, aa);
        chk(v == 16'h0002, "R10 pending kept while masked", v, 16'h0002);
    endtask

    task automatic t_collision();
        logic [15:0] v; int al, aa;
        access(1'b1, 4'd2, 16'h00FF, v, al, aa);
        @(negedge clk); evt = 8'h20; @(negedge clk); evt = 8'h00;
        // status read with a new event on the clearing edge
        @(negedge clk);
        cs_n = 1'b0; addr = 4'd1; ctl_a = tb_protb ? 1'b1 : 1'b1; ctl_b = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); evt = 8'h40;
        @(negedge clk); evt = 8'h00;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (dout_en) v = dout;
        end
        cs_n = 1'b1; ctl_b = 1'b1;
        repeat (5) @(negedge clk);
        chk(v == 16'h0020, "R9 collision read value", v, 16'h0020);
        chk(irq_n === 1'b0, "R9 collision event kept", irq_n, 0);
        access(1'b0, 4'd1, 16'h0, v, al, aa);
        chk(v == 16'h0040 && irq_n === 1'b1, "R9 second read", {v, 15'h0, irq_n}, 32'h00400001);
    endtask

    task automatic t_fifo();
        logic [15:0] v; int al, aa;
        for (int i = 0; i < 9; i++) access(1'b1, 4'd0, 16'h0040 + 16'(i), v, al, aa);
        chk(rdy === 1'b1, "R11 rdy at 9 bytes", rdy, 1);
        access(1'b1, 4'd0, 16'h0049, v, al, aa);
        chk(rdy === 1'b0, "R11 rdy drops at free=burst+2", rdy, 0);
        access(1'b1, 4'd0, 16'h004A, v, al, aa);
        access(1'b1, 4'd0, 16'h004B, v, al, aa);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(code_valid === 1'b1 && code_data == 8'(8'h40 + i), "R12/R11 code order",
                code_data, 8'h40 + i);
            code_pop = 1'b1;
            @(negedge clk);
            code_pop = 1'b0;
        end
        chk(code_valid === 1'b0 && rdy === 1'b1, "R12 drained", {code_valid, rdy}, 1);
        access(1'b1, 4'd3, 16'h0008, v, al, aa);
        access(1'b0, 4'd3, 16'h0, v, al, aa);
        chk(v == 16'h0008, "R11 burst readback", v, 8);
        for (int i = 0; i < 5; i++) access(1'b1, 4'd0, 16'h0010, v, al, aa);
        chk(rdy === 1'b1, "R11 burst 8: rdy at 5", rdy, 1);
        access(1'b1, 4'd0, 16'h0010, v, al, aa);
        chk(rdy === 1'b0, "R11 burst 8: drop at 6", rdy, 0);
    endtask

    task automatic t_typeb_swap();
        logic [15:0] v; int al, aa, w0;
        do_reset(1'b1, 1'b1, 1'b1);
        w0 = wr_seen;
        access(1'b1, 4'd7, 16'h1234, v, al, aa);
        chk(wr_seen == w0 + 1 && wr_d == 16'h3412, "R6/R3 swapped write", wr_d, 16'h3412);
        chk(al == 1, "R3 one wait cycle", al, 1);
        access(1'b0, 4'd6, 16'h0, v, al, aa);
        chk(v == 16'hC6A5, "R6 swapped read", v, 16'hC6A5);
        chk(al == 1, "R3 one wait cycle on read", al, 1);
    endtask

    task automatic t_narrow();
        logic [15:0] v; int al, aa;
        do_reset(1'b0, 1'b1, 1'b1);
        access(1'b1, 4'd9, 16'hFF77, v, al, aa);
        chk(wr_d == 16'h0077 && wr_a == 4'd9, "R7 narrow write", wr_d, 16'h0077);
        access(1'b0, 4'd6, 16'h0, v, al, aa);
        chk(v == 16'h00C6, "R7 narrow read", v, 16'h00C6);
    endtask

    bit done = 1'b0;
    initial begin
        do_reset(1'b1, 1'b0, 1'b0);
        t_reset_state();
        t_typea_wr_rd();
        t_irq();
        t_collision();
        t_fifo();
        t_typeb_swap();
        t_narrow();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule